// File: doc/BRIEF.md
# Even-Ratio Programmable Clock Divider

This block derives a slower clock from a crystal-rate input clock. A programmed code `c` sets the output period to `2*c` input cycles. A counter stage produces a tick every `c` input cycles, and a toggle flop after it flips the output on each tick, so the duty cycle is exactly 50% for every code. A code of zero does not bypass the divider: it switches the output off.

The code width is a parameter. A 5-bit instance covers divide factors 2 to 62, which suits a clock for an attached microcontroller. A 7-bit instance covers 2 to 254, which suits the switching clock of a supply converter. A standby input stops the output. When `HAS_BUF_EN` is set, a separate enable input also gates the output; otherwise that input has no effect.

A new code is taken only at an output toggle, so a code change never produces a shortened half-period. Every start begins with the output low, and the first rising edge comes after one full half-period. The status output `active_o` reports that the output is toggling.

Top module: `evendiv_clk`

## Requirements
- R1: When `code_i` is 0, `clk_o` is low and `active_o` is low from the first clock edge at which the zero code is present.
- R2: With a non-zero code c held constant, `clk_o` has a period of 2*c input cycles, with c cycles high and c cycles low. This covers c = 1 (divide by 2) up to c = 2^CODE_W-1.
- R3: At the edge where the run conditions are first met, `active_o` rises and `clk_o` stays low. The first rising edge of `clk_o` comes exactly c input cycles after that edge.
- R4: With `standby_i` high, `clk_o` and `active_o` are low from the next clock edge.
- R5: With HAS_BUF_EN = 1, `buf_en_i` low keeps `clk_o` and `active_o` low. With HAS_BUF_EN = 0, `buf_en_i` has no effect.
- R6: A change of a non-zero code while running takes effect at the next output toggle. The half-period in progress completes with the old code.
- R7: `active_o` is high exactly while the divider runs. `clk_o` is never high while `active_o` is low.
- R8: While `rst_ni` is low, `clk_o` and `active_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-rate input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | CODE_W | Divide code c; factor is 2*c, 0 = off |
| buf_en_i | input | 1 | Output enable (used only when HAS_BUF_EN = 1) |
| standby_i | input | 1 | Standby, active high; forces output off |
| clk_o | output | 1 | Divided 50%-duty clock |
| active_o | output | 1 | High while the output is toggling |

## Verification
The bench sweeps every code of the 5-bit instance and compares each sampled output bit with the value computed from `(i/c)%2`. A design with an off-by-one count, or one that drops the toggle stage, shows a wrong period or an uneven duty. For each code the bench also checks the position of the first rising edge. A design that starts high, or that starts partway through a half-period, fails that check. A code change in the middle of a half-period must stretch only the halves that follow it; a design that loads the new code at once produces a runt pulse. The bench also covers a drop to standby while the output is high, a code of zero, the enable gate on the 5-bit instance, and the largest factor (254) on a 7-bit instance where the enable has no effect.

// File: rtl/evendiv_pkg.sv
package evendiv_pkg;
  localparam int unsigned MCU_CODE_W  = 5;
  localparam int unsigned CONV_CODE_W = 7;

  function automatic int unsigned max_code(input int unsigned w);
    return (1 << w) - 1;
  endfunction
endpackage

// File: rtl/evendiv_gate.sv
module evendiv_gate #(
  parameter int unsigned CODE_W     = 5,
  parameter bit          HAS_BUF_EN = 1'b1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              buf_en_i,
  input  logic              standby_i,
  output logic              run_req_o
);
  logic en_ok;

  generate
    if (HAS_BUF_EN) begin : g_buf_en
      assign en_ok = buf_en_i;
    end else begin : g_no_buf_en
      logic unused_buf_en;
      assign unused_buf_en = buf_en_i;
      assign en_ok = 1'b1;
    end
  endgenerate

  assign run_req_o = (code_i != '0) && !standby_i && en_ok;
endmodule

// File: rtl/evendiv_cnt.sv
module evendiv_cnt #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_req_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              run_o,
  output logic              tick_o
);
  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] code_q;
  logic              run_q;

  assign tick_o = run_q && (cnt_q == code_q - CODE_W'(1));
  assign run_o  = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
      run_q  <= 1'b0;
    end else if (!run_req_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!run_q) begin
      // start: load code, full half-period before first toggle
      run_q  <= 1'b1;
      cnt_q  <= '0;
      code_q <= code_i;
    end else if (tick_o) begin
      cnt_q  <= '0;
      code_q <= code_i;
    end else begin
      cnt_q <= cnt_q + CODE_W'(1);
    end
  end
endmodule

// File: rtl/evendiv_tff.sv
module evendiv_tff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_req_i,
  input  logic tick_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= 1'b0;
    else if (!run_req_i) q_o <= 1'b0;
    else if (tick_i)    q_o <= ~q_o;
  end
endmodule

// File: rtl/evendiv_clk.sv
module evendiv_clk #(
  parameter int unsigned CODE_W     = evendiv_pkg::MCU_CODE_W,
  parameter bit          HAS_BUF_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              buf_en_i,
  input  logic              standby_i,
  output logic              clk_o,
  output logic              active_o
);
  logic run_req;
  logic tick;

  evendiv_gate #(.CODE_W(CODE_W), .HAS_BUF_EN(HAS_BUF_EN)) u_gate (
    .code_i    (code_i),
    .buf_en_i  (buf_en_i),
    .standby_i (standby_i),
    .run_req_o (run_req)
  );

  evendiv_cnt #(.CODE_W(CODE_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_req_i (run_req),
    .code_i    (code_i),
    .run_o     (active_o),
    .tick_o    (tick)
  );

  evendiv_tff u_tff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_req_i (run_req),
    .tick_i    (tick),
    .q_o       (clk_o)
  );
endmodule

// File: rtl/evendiv_chk.sv
module evendiv_chk #(
  parameter int unsigned CODE_W     = 5,
  parameter bit          HAS_BUF_EN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_i,
  input logic              buf_en_i,
  input logic              standby_i,
  input logic              clk_o,
  input logic              active_o
);
  localparam int unsigned MAXC = evendiv_pkg::max_code(CODE_W);

  logic [CODE_W:0] seg_len;
  logic            prev_clk;

  // length of the current output level while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_len  <= '0;
      prev_clk <= 1'b0;
    end else begin
      prev_clk <= clk_o;
      if (!active_o)              seg_len <= '0;
      else if (clk_o != prev_clk) seg_len <= (CODE_W+1)'(1);
      else if (seg_len <= (CODE_W+1)'(MAXC)) seg_len <= seg_len + (CODE_W+1)'(1);
    end
  end

  a_r1_zero_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == '0) |=> (!clk_o && !active_o));

  a_r4_standby_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (!clk_o && !active_o));

  a_r5_buf_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_BUF_EN && !buf_en_i) |=> !active_o);

  a_r3_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> !clk_o);

  a_r7_high_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o |-> active_o);

  a_r2_half_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (seg_len <= (CODE_W+1)'(MAXC)));

  always_comb begin
    if (!rst_ni) a_r8_reset_low: assert (!clk_o && !active_o);
  end
endmodule

bind evendiv_clk evendiv_chk #(.CODE_W(CODE_W), .HAS_BUF_EN(HAS_BUF_EN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .code_i    (code_i),
  .buf_en_i  (buf_en_i),
  .standby_i (standby_i),
  .clk_o     (clk_o),
  .active_o  (active_o)
);

// File: tb/tb_evendiv_clk.sv
module tb_evendiv_clk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] code5 = 5'd3;
  logic [6:0] code7 = 7'd0;
  logic       buf_en = 1'b1;
  logic       standby = 1'b0;
  logic       clk1, act1, clk2, act2;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  evendiv_clk #(.CODE_W(5), .HAS_BUF_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code5), .buf_en_i(buf_en),
    .standby_i(standby), .clk_o(clk1), .active_o(act1));

  evendiv_clk #(.CODE_W(7), .HAS_BUF_EN(1'b0)) dut7 (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code7), .buf_en_i(buf_en),
    .standby_i(standby), .clk_o(clk2), .active_o(act2));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run n samples on the chosen instance; index 0 is after the start edge
  task automatic run_pattern(input bit big, input int c, input int n,
                             output int mism, output int first_rise);
    mism = 0;
    first_rise = -1;
    for (int i = 0; i < n; i++) begin
      bit o, a, e;
      @(negedge clk);
      o = big ? clk2 : clk1;
      a = big ? act2 : act1;
      e = ((i / c) % 2) == 1;
      if (o !== e || a !== 1'b1) mism++;
      if (o && first_rise < 0) first_rise = i;
    end
  endtask

  task automatic go_off;
    @(negedge clk);
    standby = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int mism, fr;
    // R8: reset holds outputs low
    repeat (3) @(negedge clk);
    check(!clk1 && !act1 && !clk2 && !act2, "R8", {clk1, act1}, 0);
    standby = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R7: sweep all codes of the 5-bit instance
    for (int c = 1; c <= 31; c++) begin
      go_off();
      check(!clk1 && !act1, "R7", {clk1, act1}, 0);
      code5 = 5'(c);
      standby = 1'b0;
      run_pattern(1'b0, c, 4 * c, mism, fr);
      check(mism == 0, "R2", mism, 0);
      check(fr == c, "R3", fr, c);
    end

    // R6: code 3 -> 5 changed mid high half
    go_off();
    code5 = 5'd3;
    standby = 1'b0;
    mism = 0;
    for (int i = 0; i < 16; i++) begin
      bit e;
      @(negedge clk);
      e = (i >= 3 && i <= 5) || (i >= 11);
      if (clk1 !== e) mism++;
      if (i == 4) code5 = 5'd5;
    end
    check(mism == 0, "R6", mism, 0);

    // R4: standby while output high
    go_off();
    code5 = 5'd4;
    standby = 1'b0;
    repeat (6) @(negedge clk);
    check(clk1 == 1'b1, "R2", clk1, 1);
    standby = 1'b1;
    @(negedge clk);
    check(!clk1 && !act1, "R4", {clk1, act1}, 0);
    repeat (5) @(negedge clk);
    check(!clk1 && !act1, "R4", {clk1, act1}, 0);
    standby = 1'b0;
    run_pattern(1'b0, 4, 12, mism, fr);
    check(mism == 0 && fr == 4, "R3", mism, 0);

    // R1: zero code mid-run and held
    code5 = 5'd0;
    @(negedge clk);
    check(!clk1 && !act1, "R1", {clk1, act1}, 0);
    mism = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (clk1 || act1) mism++;
    end
    check(mism == 0, "R1", mism, 0);

    // R5: enable gate on the 5-bit instance
    go_off();
    code5 = 5'd3;
    buf_en = 1'b0;
    standby = 1'b0;
    mism = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (clk1 || act1) mism++;
    end
    check(mism == 0, "R5", mism, 0);
    buf_en = 1'b1;
    run_pattern(1'b0, 3, 12, mism, fr);
    check(mism == 0, "R5", mism, 0);

    // R2/R5: 7-bit instance, enable low has no effect
    go_off();
    code5 = 5'd0;
    buf_en = 1'b0;
    code7 = 7'd127;
    standby = 1'b0;
    run_pattern(1'b1, 127, 508, mism, fr);
    check(mism == 0, "R2", mism, 0);
    check(fr == 127, "R5", fr, 127);
    go_off();
    code7 = 7'd1;
    standby = 1'b0;
    run_pattern(1'b1, 1, 8, mism, fr);
    check(mism == 0, "R2", mism, 0);
    go_off();
    code7 = 7'd64;
    standby = 1'b0;
    run_pattern(1'b1, 64, 256, mism, fr);
    check(mism == 0, "R2", mism, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule